// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates among 32 numbered priority slots and tells the CPU which interrupt to take. Every slot collects a small group of source flags, each with its own enable bit. A slot is pending when any of its enabled sources is raised. The highest pending slot wins. The controller latches that slot and its 16-bit vector word address, then raises an interrupt request. Both stay frozen until the CPU acknowledges.

The slots fall into three classes, each with its own gating:

- **Slot 31, the reset class.** Its sources ignore all enables and always produce a reset request.
- **Slot 30, the non-maskable class.** It is gated only by the per-source enables.
- **Slots 15 to 29, the maskable class.** These also need the global interrupt enable.
- **Slots 0 to 14.** These are reserved and never win.

The controller also watches the instruction-fetch bus. A fetch from the peripheral register window (0000h to 01FFh) raises a reset request.

A reset request always overrides an interrupt in progress. It drops the interrupt request, clears the acknowledge state and points the output at the reset vector.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After the synchronous active-high reset, `irq_o` and `rst_req_o` are 0, and `slot_o` and `vec_o` are 0.
- R2: While `irq_o` is high, `vec_o` equals 0FFC0h + 2 × `slot_o`.
- R3: When several slots are pending, the highest-numbered one is latched one clock after the requests appear.
- R4: A maskable slot (15 to 29) is taken only when the source's enable and `gie_i` are both 1.
- R5: Slot 30 is taken with `gie_i` = 0, but not when its raised source's enable is 0.
- R6: Source k of slot s is bit s×8+k of `src_flag_i` and `src_en_i`. A slot is pending when any of its eight sources has both its flag and its enable set.
- R7: Slots 0 to 14 never win arbitration, whatever their flags and enables.
- R8: While `irq_o` is high, `slot_o` and `vec_o` hold even if higher requests arrive. A cycle with `ack_i` = 1 drops `irq_o` at the next edge.
- R9: A fetch strobe with an address of 01FFh or lower sets `rst_req_o` at the next edge. A fetch at 0200h or above does not.
- R10: Any raised slot-31 flag, whatever its enable, sets `rst_req_o` at the next edge. The same edge clears `irq_o` and sets `slot_o` to 31 and `vec_o` to 0FFFEh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_flag_i | input | 256 | Source request flags, 8 per slot |
| src_en_i | input | 256 | Per-source enables, same layout |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | CPU acknowledge of the latched interrupt |
| fetch_en_i | input | 1 | Instruction-fetch strobe |
| fetch_addr_i | input | 16 | Instruction-fetch address |
| irq_o | output | 1 | Interrupt request to the CPU |
| slot_o | output | 5 | Latched winning slot |
| vec_o | output | 16 | Latched vector word address |
| rst_req_o | output | 1 | Reset request |

## Verification
The assertions check the following on every cycle:

- the vector-to-slot relation;
- the freezing of the latched slot until acknowledge;
- the exclusion of reserved slots;
- the reset-override state;
- the reaction to an illegal fetch.

Only the bench scenarios can show which slot should have won. That covers the priority order, the different gating of maskable and non-maskable slots against the global enable, the OR-ing of shared sources, and the 01FFh/0200h fetch boundary.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSLOT     = 32,
  parameter int NSRC      = 8,
  parameter int RSV_SLOTS = 15,
  parameter logic [15:0] VEC_BASE   = 16'hFFC0,
  parameter logic [15:0] PERIPH_TOP = 16'h01FF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSLOT*NSRC-1:0] src_flag_i,
  input  logic [NSLOT*NSRC-1:0] src_en_i,
  input  logic                  gie_i,
  input  logic                  ack_i,
  input  logic                  fetch_en_i,
  input  logic [15:0]           fetch_addr_i,
  output logic                  irq_o,
  output logic [$clog2(NSLOT)-1:0] slot_o,
  output logic [15:0]           vec_o,
  output logic                  rst_req_o
);
  localparam int SW       = $clog2(NSLOT);
  localparam int RST_SLOT = NSLOT - 1;
  localparam int NMI_SLOT = NSLOT - 2;

  logic [NSLOT-1:0] pend;
  logic             win_v;
  logic [SW-1:0]    win;
  logic             reset_src, bad_fetch;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    wire any_src = |(src_flag_i[s*NSRC +: NSRC] & src_en_i[s*NSRC +: NSRC]);
    if (s < RSV_SLOTS || s == RST_SLOT) begin : g_off
      assign pend[s] = 1'b0;
    end else if (s == NMI_SLOT) begin : g_nmi
      assign pend[s] = any_src;
    end else begin : g_mask
      assign pend[s] = any_src & gie_i;
    end
  end

  always_comb begin
    win_v = 1'b0;
    win   = '0;
    for (int s = 0; s < NSLOT; s++)
      if (pend[s]) begin
        win_v = 1'b1;
        win   = s[SW-1:0];
      end
  end

  assign reset_src = |src_flag_i[RST_SLOT*NSRC +: NSRC];
  assign bad_fetch = fetch_en_i && (fetch_addr_i <= PERIPH_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      slot_o    <= '0;
      vec_o     <= '0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= reset_src | bad_fetch;
      if (reset_src | bad_fetch) begin
        irq_o  <= 1'b0;
        slot_o <= RST_SLOT[SW-1:0];
        vec_o  <= VEC_BASE + 16'(2 * RST_SLOT);
      end else if (irq_o) begin
        if (ack_i) irq_o <= 1'b0;
      end else if (win_v) begin
        irq_o  <= 1'b1;
        slot_o <= win;
        vec_o  <= VEC_BASE + {{(15-SW){1'b0}}, win, 1'b0};
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int SW = 5,
  parameter int RSV_SLOTS = 15,
  parameter logic [15:0] VEC_BASE   = 16'hFFC0,
  parameter logic [15:0] PERIPH_TOP = 16'h01FF
) (
  input logic          clk,
  input logic          rst,
  input logic          ack_i,
  input logic          fetch_en_i,
  input logic [15:0]   fetch_addr_i,
  input logic          irq_o,
  input logic [SW-1:0] slot_o,
  input logic [15:0]   vec_o,
  input logic          rst_req_o
);
  a_r2_vec_matches_slot: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> vec_o == VEC_BASE + {{(15-SW){1'b0}}, slot_o, 1'b0});

  a_r7_no_reserved_win: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> int'(slot_o) >= RSV_SLOTS);

  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i && !rst_req_o) ##1 !rst_req_o |-> irq_o && $stable(slot_o) && $stable(vec_o));

  a_r9_bad_fetch_resets: assert property (@(posedge clk) disable iff (rst)
    (fetch_en_i && fetch_addr_i <= PERIPH_TOP) |=> rst_req_o);

  a_r10_reset_overrides: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> !irq_o && vec_o == 16'hFFFE);
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.SW(SW), .RSV_SLOTS(RSV_SLOTS), .VEC_BASE(VEC_BASE),
  .PERIPH_TOP(PERIPH_TOP)) u_chk (
  .clk(clk), .rst(rst), .ack_i(ack_i), .fetch_en_i(fetch_en_i),
  .fetch_addr_i(fetch_addr_i), .irq_o(irq_o), .slot_o(slot_o), .vec_o(vec_o),
  .rst_req_o(rst_req_o));

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic clk = 0, rst = 1;
  logic [255:0] flag = '0, en = '0;
  logic gie = 0, ack = 0, fen = 0;
  logic [15:0] faddr = 16'h8000;
  logic irq, rreq;
  logic [4:0] slot;
  logic [15:0] vec;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst(rst), .src_flag_i(flag), .src_en_i(en), .gie_i(gie), .ack_i(ack),
    .fetch_en_i(fen), .fetch_addr_i(faddr), .irq_o(irq), .slot_o(slot), .vec_o(vec),
    .rst_req_o(rreq));

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic clear_all();
    flag = '0; en = '0; ack = 1; fen = 0;
    step(); step();
    ack = 0;
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0); chk("R1 rst_req", rreq, 0);
    chk("R1 slot", slot, 0); chk("R1 vec", vec, 0);
  endtask

  task automatic t_priority();
    gie = 1;
    flag[20*8+3] = 1; en[20*8+3] = 1;
    flag[25*8] = 1;   en[25*8] = 1;
    flag[17*8+7] = 1; en[17*8+7] = 1;
    step();
    chk("R3 irq", irq, 1); chk("R3 slot", slot, 25);
    chk("R2 vec", vec, 16'hFFC0 + 2*25);
    flag[29*8+1] = 1; en[29*8+1] = 1;
    step();
    chk("R8 held slot", slot, 25); chk("R8 held vec", vec, 16'hFFF2);
    ack = 1; flag[25*8] = 0; step(); ack = 0;
    chk("R8 irq drop", irq, 0);
    step();
    chk("R3 next winner", slot, 29); chk("R2 vec 29", vec, 16'hFFFA);
    clear_all();
  endtask

  task automatic t_mask();
    gie = 0;
    flag[22*8] = 1; en[22*8] = 1;
    step(); step();
    chk("R4 gie off", irq, 0);
    gie = 1; en[22*8] = 0; step(); step();
    chk("R4 en off", irq, 0);
    en[22*8] = 1; step();
    chk("R4 both on", irq, 1); chk("R4 slot", slot, 22);
    clear_all();
  endtask

  task automatic t_nmi();
    gie = 0;
    flag[30*8+2] = 1; en[30*8+2] = 0; step(); step();
    chk("R5 nmi blocked by enable", irq, 0);
    en[30*8+2] = 1; step();
    chk("R5 nmi gie off", irq, 1); chk("R5 slot", slot, 30);
    chk("R2 vec 30", vec, 16'hFFFC);
    clear_all();
  endtask

  task automatic t_shared();
    gie = 1;
    flag[20*8 +: 8] = 8'b0101_0000; en[20*8 +: 8] = 8'b0010_1111; step(); step();
    chk("R6 no enabled match", irq, 0);
    en[20*8+6] = 1; step();
    chk("R6 shared slot", irq, 1); chk("R6 slot", slot, 20);
    clear_all();
  endtask

  task automatic t_reserved();
    gie = 1;
    for (int s = 0; s < 15; s++) begin flag[s*8 +: 8] = '1; en[s*8 +: 8] = '1; end
    step(); step();
    chk("R7 reserved ignored", irq, 0);
    flag[15*8] = 1; en[15*8] = 1; step();
    chk("R7 slot 15 wins", slot, 15);
    clear_all();
  endtask

  task automatic t_fetch();
    faddr = 16'h0200; fen = 1; step();
    chk("R9 0200 no reset", rreq, 0);
    faddr = 16'h01FF; step();
    chk("R9 01FF reset", rreq, 1); chk("R9 vec", vec, 16'hFFFE);
    faddr = 16'h0000; fen = 0; step();
    chk("R9 no strobe", rreq, 0);
    faddr = 16'h8000;
  endtask

  task automatic t_reset_src();
    gie = 1; flag[27*8] = 1; en[27*8] = 1; step();
    chk("R10 pre irq", irq, 1);
    flag[27*8] = 0; flag[31*8+4] = 1; step();
    chk("R10 rst_req", rreq, 1); chk("R10 irq cleared", irq, 0);
    chk("R10 slot", slot, 31); chk("R10 vec", vec, 16'hFFFE);
    flag[31*8+4] = 0; step();
    chk("R10 release", rreq, 0); chk("R10 no stale irq", irq, 0);
    clear_all();
  endtask

  initial begin
    step(); step(); rst = 0;
    t_reset();
    t_priority();
    t_mask();
    t_nmi();
    t_shared();
    t_reserved();
    t_fetch();
    t_reset_src();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule